// File: doc/BRIEF.md
# Multi-Error Correction Applicator

This block sits after a syndrome engine that can locate up to four bad bytes in a 512-byte sector. For each sector it receives the ten stored parity bytes, a flag saying that every syndrome word is zero, the engine's 4-bit correction state, a 2-bit error-count field, and two address words and two value words. Each of these words carries two error pairs. From these it decides whether the sector is clean, erased, uncorrectable or fixable. When the sector is fixable, it patches the sector in an external dual-port byte buffer, one byte at a time. Each patch is a read followed by a write of the byte XORed with the reported error value.

The engine reports positions in reversed form. The buffer offset is 519 minus the reported 10-bit address. A result that falls outside the 512 data bytes points into the parity area. No memory access is made for it, but it still counts toward the reported total. A job starts with a one-cycle `start` pulse. It ends with a one-cycle `done` pulse, and at that point `uncorrectable` and `corrected_count` become valid. Both hold until the next job completes.

Top module: `ecc_fix_applier`

## Requirements
- R1: When all ten parity bytes equal 0xFF the sector is treated as erased. This check takes priority over every other input. `done` pulses in the cycle after the start edge with `uncorrectable`=0 and `corrected_count`=0, and the buffer is not accessed.
- R2: When the parity is not erased and `syn_zero`=1, the result is clean (`uncorrectable`=0, count 0). `done` follows after one cycle and the buffer is not accessed.
- R3: Otherwise, `corr_state` 0 gives a clean result. Codes 1 and 4 to 15 give `uncorrectable`=1 with count 0. In all of these cases `done` follows after one cycle and the buffer is not accessed.
- R4: `corr_state` 2 or 3 starts a fix pass of `err_cnt`+1 fixes (1 to 4). On completion `corrected_count` equals `err_cnt`+1 and `uncorrectable`=0.
- R5: Pair 1 takes its address from bits [9:0] of `addr_word_a` and its value from bits [7:0] of `val_word_a`. Pair 2 uses bits [25:16] and [23:16] of the same two words. Pairs 3 and 4 use the same fields of `addr_word_b` and `val_word_b`. Fixes run in pair order 1, 2, 3, 4.
- R6: A fix XORs its 8-bit value into the buffer byte at offset 519 minus its 10-bit address. No other byte changes.
- R7: A fix whose offset falls outside 0..511 makes no buffer read or write. This covers addresses below 8 and addresses above 519. The fix still uses its two cycles and is still included in `corrected_count`.
- R8: Each fix is a read cycle followed by a write cycle to the same offset, and read and write are never enabled together. With n fixes, `done` is seen 2n+1 cycles after the start edge's cycle.
- R9: Two pairs naming the same offset both take effect. The second read observes the first write.
- R10: All inputs are captured at the accepted start. A `start` pulse during a fix pass is ignored, and input changes during the pass have no effect.
- R11: After reset, `done`, `uncorrectable`, `corrected_count`, `buf_rd_en` and `buf_wr_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a job (ignored while a pass runs) |
| parity_bytes | input | 80 | Ten stored parity bytes |
| syn_zero | input | 1 | All syndrome words are zero |
| corr_state | input | 4 | Engine correction state code |
| err_cnt | input | 2 | Error count minus one |
| addr_word_a | input | 32 | Reversed addresses of pairs 1 (low half) and 2 (high half) |
| addr_word_b | input | 32 | Reversed addresses of pairs 3 and 4 |
| val_word_a | input | 32 | Error values of pairs 1 and 2 |
| val_word_b | input | 32 | Error values of pairs 3 and 4 |
| buf_rd_en | output | 1 | Buffer read enable |
| buf_rd_addr | output | 9 | Buffer read offset |
| buf_rd_data | input | 8 | Buffer read data, one cycle after the read |
| buf_wr_en | output | 1 | Buffer write enable |
| buf_wr_addr | output | 9 | Buffer write offset |
| buf_wr_data | output | 8 | Patched byte |
| done | output | 1 | One-cycle completion pulse |
| uncorrectable | output | 1 | Sector could not be repaired |
| corrected_count | output | 3 | Number of fixes in the last pass |

## Verification
The hardest situation to reach from the ports is a `start` pulse that arrives while a pass is running. The stimulus for it carries erased parity and different address words, so that accepting it would produce an early extra `done` and would also patch wrong bytes. The scoreboard can see both effects. The other difficult cases are pairs that point into the parity area and two pairs that hit the same byte. They are reached by choosing raw addresses of 3, 600, 8 and 519, and two pairs with a shared offset. The bench checks their effect by comparing the whole buffer against a reference copy and by counting buffer enables per job.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;
    localparam int DATA_BYTES = 512;
    localparam int PAR_BYTES  = 10;
    localparam int BYTE_W     = 8;
    localparam int RAW_AW     = 10;
    localparam int MAX_FIX    = 4;
    localparam int WORD_W     = 32;
    localparam int HALF_W     = WORD_W / 2;
    localparam int ADDR_BIAS  = DATA_BYTES + 7;
    localparam int AW         = $clog2(DATA_BYTES);
    localparam int CNT_W      = $clog2(MAX_FIX + 1);
    localparam int IDX_W      = $clog2(MAX_FIX);
    localparam int PAIR_WORDS = (MAX_FIX + 1) / 2;
    localparam int WORDS_W    = PAIR_WORDS * WORD_W;

    typedef enum logic [1:0] {PH_IDLE, PH_RD, PH_WR} phase_e;
    typedef enum logic [1:0] {CL_CLEAN, CL_FAIL, CL_FIX} class_e;
endpackage

// File: rtl/ecc_fix_classify.sv
module ecc_fix_classify
    import ecc_fix_pkg::*;
(
    input  logic [PAR_BYTES*BYTE_W-1:0] parity_bytes,
    input  logic                        syn_zero,
    input  logic [3:0]                  corr_state,
    output class_e                      cls
);
    logic erased;
    assign erased = &parity_bytes;

    always_comb begin
        if (erased || syn_zero) begin
            cls = CL_CLEAN;
        end else begin
            case (corr_state)
                4'd0:       cls = CL_CLEAN;
                4'd2, 4'd3: cls = CL_FIX;
                default:    cls = CL_FAIL;
            endcase
        end
    end
endmodule

// File: rtl/ecc_fix_pair_mux.sv
module ecc_fix_pair_mux
    import ecc_fix_pkg::*;
(
    input  logic [WORDS_W-1:0] addr_words,
    input  logic [WORDS_W-1:0] val_words,
    input  logic [IDX_W-1:0]   idx,
    output logic [AW-1:0]      offset,
    output logic [BYTE_W-1:0]  value,
    output logic               in_range
);
    localparam logic [RAW_AW:0] BIAS_V  = (RAW_AW+1)'(ADDR_BIAS);
    localparam logic [RAW_AW:0] LIMIT_V = (RAW_AW+1)'(DATA_BYTES);

    logic [RAW_AW-1:0] raw_a [MAX_FIX];
    logic [BYTE_W-1:0] val_a [MAX_FIX];

    for (genvar k = 0; k < MAX_FIX; k++) begin : g_pair
        assign raw_a[k] = addr_words[(k/2)*WORD_W + (k%2)*HALF_W +: RAW_AW];
        assign val_a[k] = val_words[(k/2)*WORD_W + (k%2)*HALF_W +: BYTE_W];
    end

    logic [RAW_AW:0] raw_x;
    logic [RAW_AW:0] diff;
    assign raw_x    = {1'b0, raw_a[idx]};
    assign diff     = BIAS_V - raw_x;
    assign in_range = (raw_x <= BIAS_V) && (diff < LIMIT_V);
    assign offset   = diff[AW-1:0];
    assign value    = val_a[idx];

    logic unused_bits;
    assign unused_bits = ^{addr_words, val_words, diff};
endmodule

// File: rtl/ecc_fix_applier.sv
module ecc_fix_applier
    import ecc_fix_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [PAR_BYTES*BYTE_W-1:0] parity_bytes,
    input  logic                        syn_zero,
    input  logic [3:0]                  corr_state,
    input  logic [IDX_W-1:0]            err_cnt,
    input  logic [WORD_W-1:0]           addr_word_a,
    input  logic [WORD_W-1:0]           addr_word_b,
    input  logic [WORD_W-1:0]           val_word_a,
    input  logic [WORD_W-1:0]           val_word_b,
    output logic                        buf_rd_en,
    output logic [AW-1:0]               buf_rd_addr,
    input  logic [BYTE_W-1:0]           buf_rd_data,
    output logic                        buf_wr_en,
    output logic [AW-1:0]               buf_wr_addr,
    output logic [BYTE_W-1:0]           buf_wr_data,
    output logic                        done,
    output logic                        uncorrectable,
    output logic [CNT_W-1:0]            corrected_count
);
    typedef struct packed {
        phase_e             phase;
        logic [IDX_W-1:0]   idx;
        logic [IDX_W-1:0]   last;
        logic               done;
        logic               uncorr;
        logic [CNT_W-1:0]   count;
        logic [WORDS_W-1:0] addr_w;
        logic [WORDS_W-1:0] val_w;
    } fix_state_t;

    fix_state_t st_d, st_q;
    class_e     cls;
    logic [AW-1:0]     fix_off;
    logic [BYTE_W-1:0] fix_val;
    logic              fix_ok;

    ecc_fix_classify u_cls (
        .parity_bytes (parity_bytes),
        .syn_zero     (syn_zero),
        .corr_state   (corr_state),
        .cls          (cls)
    );

    ecc_fix_pair_mux u_mux (
        .addr_words (st_q.addr_w),
        .val_words  (st_q.val_w),
        .idx        (st_q.idx),
        .offset     (fix_off),
        .value      (fix_val),
        .in_range   (fix_ok)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.addr_w = {addr_word_b, addr_word_a};
                    st_d.val_w  = {val_word_b, val_word_a};
                    st_d.idx    = '0;
                    st_d.last   = err_cnt;
                    case (cls)
                        CL_CLEAN: begin
                            st_d.done   = 1'b1;
                            st_d.uncorr = 1'b0;
                            st_d.count  = '0;
                        end
                        CL_FAIL: begin
                            st_d.done   = 1'b1;
                            st_d.uncorr = 1'b1;
                            st_d.count  = '0;
                        end
                        default: begin
                            st_d.phase  = PH_RD;
                            st_d.uncorr = 1'b0;
                            st_d.count  = '0;
                        end
                    endcase
                end
            end
            PH_RD: begin
                st_d.phase = PH_WR;
            end
            PH_WR: begin
                if (st_q.idx == st_q.last) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                    st_d.count = CNT_W'(st_q.last) + CNT_W'(1);
                end else begin
                    st_d.phase = PH_RD;
                    st_d.idx   = st_q.idx + IDX_W'(1);
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, idx: '0, last: '0, done: 1'b0,
                      uncorr: 1'b0, count: '0, addr_w: '0, val_w: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign buf_rd_en       = (st_q.phase == PH_RD) && fix_ok;
    assign buf_rd_addr     = fix_off;
    assign buf_wr_en       = (st_q.phase == PH_WR) && fix_ok;
    assign buf_wr_addr     = fix_off;
    assign buf_wr_data     = buf_rd_data ^ fix_val;
    assign done            = st_q.done;
    assign uncorrectable   = st_q.uncorr;
    assign corrected_count = st_q.count;
endmodule

// File: rtl/ecc_fix_applier_chk.sv
module ecc_fix_applier_chk
    import ecc_fix_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 buf_rd_en,
    input logic [AW-1:0]        buf_rd_addr,
    input logic                 buf_wr_en,
    input logic [AW-1:0]        buf_wr_addr,
    input logic                 done,
    input logic                 uncorrectable,
    input logic [CNT_W-1:0]     corrected_count
);
    assert_wr_after_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |-> ($past(buf_rd_en) && buf_wr_addr == $past(buf_rd_addr)));

    assert_no_dual_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_rd_en && buf_wr_en));

    assert_wr_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |=> !buf_wr_en);

    assert_fail_zero_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && uncorrectable) |-> corrected_count == '0);

    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> corrected_count <= CNT_W'(MAX_FIX));

    assert_idle_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(buf_rd_en || buf_wr_en));
endmodule

bind ecc_fix_applier ecc_fix_applier_chk u_chk (.*);

// File: tb/ecc_fix_applier_test.sv
module ecc_fix_applier_test;
    import ecc_fix_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, start, syn_zero;
    logic [79:0] parity_bytes;
    logic [3:0]  corr_state;
    logic [1:0]  err_cnt;
    logic [31:0] addr_word_a, addr_word_b, val_word_a, val_word_b;
    logic buf_rd_en, buf_wr_en, done, uncorrectable;
    logic [8:0] buf_rd_addr, buf_wr_addr;
    logic [7:0] buf_rd_data, buf_wr_data;
    logic [2:0] corrected_count;

    ecc_fix_applier uut (.*);

    logic [7:0] mem [512];
    logic [7:0] ref_mem [512];
    always @(posedge clk) begin
        if (buf_rd_en) buf_rd_data <= mem[buf_rd_addr];
        if (buf_wr_en) mem[buf_wr_addr] <= buf_wr_data;
    end

    typedef struct {
        logic  uc;
        int    cnt;
        int    lat;
        int    acc;
        string tag;
    } exp_t;
    exp_t sb[$];

    int n_chk = 0, n_bad = 0, cyc = 0, start_cyc = 0, acc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // monitor: pops expected results as the design reports them
    exp_t e;
    always @(negedge clk) begin
        if (rst_n) begin
            if (buf_rd_en) acc++;
            if (buf_wr_en) acc++;
            if (done) begin
                if (sb.size() == 0) begin
                    check("R10", "unexpected done", 1, 0);
                end else begin
                    e = sb.pop_front();
                    check(e.tag, "uncorrectable", int'(uncorrectable), int'(e.uc));
                    check(e.tag, "corrected_count", int'(corrected_count), e.cnt);
                    check(e.tag, "latency (R8)", cyc - start_cyc, e.lat);
                    check(e.tag, "buffer accesses", acc, e.acc);
                end
                acc = 0;
            end
        end
    end

    function automatic logic [9:0] raw_of(int off);
        return 10'(519 - off);
    endfunction

    function automatic logic [31:0] pk_a(logic [9:0] lo, logic [9:0] hi);
        return {6'd0, hi, 6'd0, lo};
    endfunction

    function automatic logic [31:0] pk_v(logic [7:0] lo, logic [7:0] hi);
        return {8'd0, hi, 8'd0, lo};
    endfunction

    // driver: computes expectation, pushes it, runs the job, checks the buffer
    task automatic run_job(logic [79:0] par, logic sz, logic [3:0] cs, logic [1:0] cf,
                           logic [31:0] aa, logic [31:0] ab, logic [31:0] va,
                           logic [31:0] vb, bit poke, string tag);
        exp_t x;
        logic clean, fail;
        int n, diffs;
        logic [63:0] aw, vw;
        clean = (&par) || sz || (cs == 4'd0);
        fail  = !clean && !(cs == 4'd2 || cs == 4'd3);
        n     = (clean || fail) ? 0 : int'(cf) + 1;
        aw = {ab, aa};
        vw = {vb, va};
        x.uc = fail; x.cnt = n; x.lat = 2 * n + 1; x.acc = 0; x.tag = tag;
        for (int k = 0; k < n; k++) begin
            int raw, off;
            raw = int'(aw[(k/2)*32 + (k%2)*16 +: 10]);
            off = 519 - raw;
            if (off >= 0 && off < 512) begin
                ref_mem[off] = ref_mem[off] ^ vw[(k/2)*32 + (k%2)*16 +: 8];
                x.acc += 2;
            end
        end
        sb.push_back(x);
        parity_bytes = par; syn_zero = sz; corr_state = cs; err_cnt = cf;
        addr_word_a = aa; addr_word_b = ab; val_word_a = va; val_word_b = vb;
        start = 1'b1;
        start_cyc = cyc;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            start = 1'b1;
            parity_bytes = {80{1'b1}};
            addr_word_a = pk_a(raw_of(300), raw_of(301));
            val_word_a  = pk_v(8'hEE, 8'hDD);
            @(negedge clk);
            start = 1'b0;
        end
        while (sb.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        diffs = 0;
        for (int i = 0; i < 512; i++) if (mem[i] !== ref_mem[i]) diffs++;
        check(tag, "buffer byte mismatches", diffs, 0);
    endtask

    localparam logic [79:0] PAR_N = 80'h0123456789ABCDEF0011;
    localparam logic [79:0] PAR_E = {80{1'b1}};

    bit finished = 0;
    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 512; i++) begin
            mem[i] = 8'(i * 7 + 3);
            ref_mem[i] = 8'(i * 7 + 3);
        end
        rst_n = 1'b0; start = 1'b0; syn_zero = 1'b0; parity_bytes = '0;
        corr_state = '0; err_cnt = '0;
        addr_word_a = '0; addr_word_b = '0; val_word_a = '0; val_word_b = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11", "done", int'(done), 0);
        check("R11", "uncorrectable", int'(uncorrectable), 0);
        check("R11", "corrected_count", int'(corrected_count), 0);
        check("R11", "enables", int'(buf_rd_en) + int'(buf_wr_en), 0);

        // R1 erased parity overrides a fix-ready state
        run_job(PAR_E, 1'b0, 4'd3, 2'd3, pk_a(raw_of(1), raw_of(2)), pk_a(raw_of(3), raw_of(4)),
                pk_v(8'h01, 8'h02), pk_v(8'h03, 8'h04), 0, "R1");
        // R2 zero syndrome
        run_job(PAR_N, 1'b1, 4'd3, 2'd3, pk_a(raw_of(1), raw_of(2)), pk_a(raw_of(3), raw_of(4)),
                pk_v(8'h01, 8'h02), pk_v(8'h03, 8'h04), 0, "R2");
        // R3 state codes 0, 1 and an undefined code
        run_job(PAR_N, 1'b0, 4'd0, 2'd3, pk_a(raw_of(5), raw_of(6)), 32'd0,
                pk_v(8'hFF, 8'hFF), 32'd0, 0, "R3");
        run_job(PAR_N, 1'b0, 4'd1, 2'd3, pk_a(raw_of(5), raw_of(6)), 32'd0,
                pk_v(8'hFF, 8'hFF), 32'd0, 0, "R3");
        run_job(PAR_N, 1'b0, 4'd9, 2'd1, pk_a(raw_of(5), raw_of(6)), 32'd0,
                pk_v(8'hFF, 8'hFF), 32'd0, 0, "R3");
        // R4 R6 single fix, other pairs must stay unused
        run_job(PAR_N, 1'b0, 4'd2, 2'd0, pk_a(raw_of(100), raw_of(101)),
                pk_a(raw_of(102), raw_of(103)), pk_v(8'h5A, 8'h77), pk_v(8'h66, 8'h55), 0, "R6");
        // R5 four pairs from both words, edge offsets 0 and 511
        run_job(PAR_N, 1'b0, 4'd3, 2'd3, pk_a(raw_of(0), raw_of(511)),
                pk_a(raw_of(37), raw_of(200)), pk_v(8'h11, 8'h22), pk_v(8'h33, 8'h44), 0, "R5");
        // R7 parity-area and out-of-window addresses are counted but not applied
        run_job(PAR_N, 1'b0, 4'd2, 2'd2, pk_a(10'd3, 10'd600),
                pk_a(raw_of(7), raw_of(8)), pk_v(8'hA5, 8'hC3), pk_v(8'h81, 8'h18), 0, "R7");
        // R9 two pairs on the same byte
        run_job(PAR_N, 1'b0, 4'd3, 2'd1, pk_a(raw_of(45), raw_of(45)), 32'd0,
                pk_v(8'h0F, 8'hF0), 32'd0, 0, "R9");
        // R10 start and input changes during a running pass
        run_job(PAR_N, 1'b0, 4'd2, 2'd2, pk_a(raw_of(400), raw_of(401)),
                pk_a(raw_of(402), raw_of(403)), pk_v(8'h3C, 8'hC3), pk_v(8'h99, 8'h42), 1, "R10");

        finished = 1;
        summary();
        $finish;
    end
endmodule